// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog Timer

This block guards a processor against hangs. Software controls it through a single write-only control word made of a run bit and a 3-bit key. After reset the watchdog sits idle. A write with the run bit set arms it and stores the written key.

From then on, only a write carrying the bitwise inverse of the stored key counts as service. With the run bit set, such a write restarts the timeout and the inverse becomes the new key. With the run bit clear, it disarms the watchdog. Any other write while armed just overwrites the stored key, and the timeout keeps running.

If no service arrives within a first window, the block raises a non-maskable interrupt request. The request is held until valid service arrives. If a second, shorter window then also passes without service, the block emits a one-cycle chip reset pulse and falls back to idle. Both windows are parameters counted in clock cycles.

Top module: `keyed_watchdog`

## Requirements
- R1: After a synchronous reset the watchdog is idle, with `nmi_req` and `chip_rst` both low.
- R2: While idle, a write with `wr_run`=0 has no effect: the block stays idle and never raises `nmi_req` or `chip_rst`.
- R3: While idle, a write with `wr_run`=1 and key K arms the watchdog, stores K as the key and starts the first window.
- R4: While armed, a write with `wr_run`=0 and key equal to the bitwise inverse of the stored key disarms the watchdog. It clears `nmi_req` and cancels any pending reset.
- R5: While armed, a write with `wr_run`=1 and key equal to the bitwise inverse of the stored key does three things: it restarts the first window, makes that inverse the new stored key, and clears `nmi_req`.
- R6: While armed, a write whose key is not the inverse of the stored key replaces the stored key and does not restart or stop any window.
- R7: `nmi_req` rises on the NMI_CYCLES-th rising edge after the arming or restarting edge if no valid service occurs in between. It then stays high until valid service or the reset pulse.
- R8: `chip_rst` is high for exactly one cycle, on the RST_CYCLES-th edge after `nmi_req` rose, if no valid service occurs in between. On that same edge `nmi_req` drops and the watchdog returns to idle.
- R9: Valid service on the same edge at which a window would expire takes priority, so no `nmi_req` rise and no reset pulse occur on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control-word write strobe, one write per cycle |
| wr_run | input | 1 | Run bit of the written control word |
| wr_key | input | KEY_W | Key field of the written control word |
| nmi_req | output | 1 | Registered non-maskable interrupt request |
| chip_rst | output | 1 | Registered one-cycle chip reset pulse |

## Verification
The bench builds the block with NMI_CYCLES=20 and RST_CYCLES=6, so a full escalation from arming to reset pulse takes only 26 cycles. These short windows let a few thousand random cycles pass through many complete NMI-then-reset sequences, restarts and stops, while the random writes draw keys both as the exact inverse and as arbitrary values. They also let directed sequences place service exactly on the expiry edge of either window, and on the cycle just before it.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [1:0] {
    WD_IDLE  = 2'd0,
    WD_ARMED = 2'd1,
    WD_ALERT = 2'd2
  } wd_state_e;

  localparam int unsigned WD_STAGES = 2;
endpackage

// File: rtl/wdg_stage_counter.sv
module wdg_stage_counter #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expire
);
  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign expire = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= expire ? '0 : cnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R7

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!run && !clear) |=> $stable(cnt)); // R7
endmodule

// File: rtl/wdg_key_fsm.sv
module wdg_key_fsm
  import wdg_pkg::*;
#(
  parameter int unsigned KEY_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_run,
  input  logic [KEY_W-1:0] wr_key,
  input  logic             t1_exp,
  input  logic             t2_exp,
  output logic             t1_run,
  output logic             t2_run,
  output logic             cnt_clr,
  output logic             nmi_q,
  output logic             crst_q
);
  wd_state_e        state;
  logic [KEY_W-1:0] key_q;
  logic             svc;

  // valid service: armed and the written key is the inverse of the stored one
  assign svc     = (state != WD_IDLE) && wr_en && (wr_key == ~key_q);
  assign t1_run  = (state == WD_ARMED);
  assign t2_run  = (state == WD_ALERT);
  assign cnt_clr = svc || (state == WD_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= WD_IDLE;
      key_q  <= '0;
      nmi_q  <= 1'b0;
      crst_q <= 1'b0;
    end else begin
      crst_q <= 1'b0;
      if (state == WD_IDLE) begin
        if (wr_en && wr_run) begin
          state <= WD_ARMED;
          key_q <= wr_key;
        end
      end else if (svc) begin
        key_q <= wr_key;
        nmi_q <= 1'b0;
        state <= wr_run ? WD_ARMED : WD_IDLE;
      end else begin
        if (wr_en) begin
          key_q <= wr_key;
        end
        if (state == WD_ARMED && t1_exp) begin
          state <= WD_ALERT;
          nmi_q <= 1'b1;
        end else if (state == WD_ALERT && t2_exp) begin
          state  <= WD_IDLE;
          nmi_q  <= 1'b0;
          crst_q <= 1'b1;
        end
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == WD_IDLE) |-> !nmi_q); // R1

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (state == WD_IDLE && !(wr_en && wr_run)) |=> (state == WD_IDLE && !nmi_q && !crst_q)); // R2

  AST_START_KEY: assert property (@(posedge clk) disable iff (rst)
    (state == WD_IDLE && wr_en && wr_run) |=> (state == WD_ARMED && key_q == $past(wr_key))); // R3

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (svc && !wr_run) |=> (state == WD_IDLE && !nmi_q && !crst_q)); // R4

  AST_RESTART_KEY: assert property (@(posedge clk) disable iff (rst)
    (svc && wr_run) |=> (state == WD_ARMED && !nmi_q && key_q == ~$past(key_q))); // R5

  AST_BAD_KEY_STORED: assert property (@(posedge clk) disable iff (rst)
    (state != WD_IDLE && wr_en && !svc) |=> (key_q == $past(wr_key))); // R6

  AST_NMI_HELD: assert property (@(posedge clk) disable iff (rst)
    (nmi_q && !svc && !t2_exp) |=> nmi_q); // R7

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    crst_q |=> !crst_q); // R8

  AST_RST_AFTER_NMI: assert property (@(posedge clk) disable iff (rst)
    $rose(crst_q) |-> ($past(nmi_q) && !nmi_q)); // R8

  AST_SERVICE_WINS: assert property (@(posedge clk) disable iff (rst)
    (svc && (t1_exp || t2_exp)) |=> (!nmi_q && !crst_q)); // R9
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdg_pkg::*;
#(
  parameter int unsigned KEY_W      = 3,
  parameter int unsigned NMI_CYCLES = 5_000_000,
  parameter int unsigned RST_CYCLES = 165_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_run,
  input  logic [KEY_W-1:0] wr_key,
  output logic             nmi_req,
  output logic             chip_rst
);
  logic [WD_STAGES-1:0] st_run;
  logic [WD_STAGES-1:0] st_exp;
  logic                 cnt_clr;

  wdg_key_fsm #(.KEY_W(KEY_W)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_run  (wr_run),
    .wr_key  (wr_key),
    .t1_exp  (st_exp[0]),
    .t2_exp  (st_exp[1]),
    .t1_run  (st_run[0]),
    .t2_run  (st_run[1]),
    .cnt_clr (cnt_clr),
    .nmi_q   (nmi_req),
    .crst_q  (chip_rst)
  );

  for (genvar g = 0; g < WD_STAGES; g++) begin : g_stage
    localparam int unsigned LIM = (g == 0) ? NMI_CYCLES : RST_CYCLES;
    wdg_stage_counter #(.LIMIT(LIM)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .clear  (cnt_clr),
      .run    (st_run[g]),
      .expire (st_exp[g])
    );
  end

  AST_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(nmi_req && chip_rst)); // R8

  AST_ONE_STAGE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(st_run)); // R7
endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;
  localparam int unsigned KW   = 3;
  localparam int unsigned NMIC = 20;
  localparam int unsigned RSTC = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          wr_run = 1'b0;
  logic [KW-1:0] wr_key = '0;
  logic          nmi_req;
  logic          chip_rst;

  int checks = 0;
  int fails  = 0;
  int ncyc   = 0;
  bit done   = 0;

  // reference model state: 0 idle, 1 armed, 2 alert
  int          m_st  = 0;
  logic [KW-1:0] m_key = '0;
  int          m_cnt = 0;
  bit          m_nmi = 0;
  bit          m_rst = 0;

  always #10 clk = ~clk;

  keyed_watchdog #(.KEY_W(KW), .NMI_CYCLES(NMIC), .RST_CYCLES(RSTC)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_run(wr_run), .wr_key(wr_key),
    .nmi_req(nmi_req), .chip_rst(chip_rst)
  );

  function automatic bit is_service(int st, logic [KW-1:0] k, logic [KW-1:0] stored, bit w);
    return (st != 0) && w && (k == ~stored);
  endfunction

  task automatic model_edge(bit r, bit w, bit e, logic [KW-1:0] k);
    m_rst = 0;
    if (r) begin
      m_st = 0; m_key = '0; m_cnt = 0; m_nmi = 0;
    end else if (m_st == 0) begin
      if (w && e) begin m_st = 1; m_key = k; m_cnt = 0; end
    end else if (is_service(m_st, k, m_key, w)) begin
      m_key = k; m_nmi = 0; m_cnt = 0; m_st = e ? 1 : 0;
    end else begin
      if (w) m_key = k;
      if (m_st == 1) begin
        if (m_cnt == NMIC - 1) begin m_st = 2; m_nmi = 1; m_cnt = 0; end
        else m_cnt++;
      end else begin
        if (m_cnt == RSTC - 1) begin m_st = 0; m_nmi = 0; m_rst = 1; m_cnt = 0; end
        else m_cnt++;
      end
    end
  endtask

  // one cycle: drive at negedge, model the edge, compare at the next negedge
  task automatic cyc(bit r, bit w, bit e, logic [KW-1:0] k, string req);
    rst = r; wr_en = w; wr_run = e; wr_key = k;
    @(posedge clk);
    model_edge(r, w, e, k);
    @(negedge clk);
    checks++;
    if (nmi_req !== m_nmi || chip_rst !== m_rst) begin
      fails++;
      $display("FAIL %s: nmi_req=%0b chip_rst=%0b expected nmi_req=%0b chip_rst=%0b (cycle %0d)",
               req, nmi_req, chip_rst, m_nmi, m_rst, ncyc);
    end
  endtask

  task automatic idle_cycles(int n, string req);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, '0, req);
  endtask

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 200000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 200000", ncyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    cyc(1, 0, 0, '0, "R1");
    cyc(1, 1, 1, 3'd5, "R1");
    idle_cycles(2, "R1");

    // R2: idle writes with run bit clear do nothing
    cyc(0, 1, 0, 3'd2, "R2");
    cyc(0, 1, 0, 3'd7, "R2");
    idle_cycles(NMIC + RSTC + 4, "R2");

    // R3 / R7: arm with key 5, NMI exactly NMIC edges later, held
    cyc(0, 1, 1, 3'd5, "R3");
    idle_cycles(NMIC - 1, "R7");
    cyc(0, 0, 0, '0, "R7");
    idle_cycles(2, "R7");
    // R6: wrong key while alert keeps NMI, key becomes 3
    cyc(0, 1, 1, 3'd3, "R6");
    // R5: inverse of 3 is 4, restarts and clears NMI
    cyc(0, 1, 1, 3'd4, "R5");
    idle_cycles(NMIC - 1, "R5");
    cyc(0, 0, 0, '0, "R7");
    // R8: reset pulse after RSTC edges, then idle
    idle_cycles(RSTC - 1, "R8");
    cyc(0, 0, 0, '0, "R8");
    idle_cycles(NMIC + 3, "R8");

    // R6: wrong-key write mid-window does not restart
    cyc(0, 1, 1, 3'd1, "R3");
    idle_cycles(5, "R6");
    cyc(0, 1, 1, 3'd1, "R6");
    idle_cycles(NMIC - 7, "R6");
    cyc(0, 0, 0, '0, "R6");
    // R4: stop during alert with inverse of 1 (6), no reset later
    cyc(0, 1, 0, 3'd6, "R4");
    idle_cycles(RSTC + NMIC + 2, "R4");

    // R9: service on the first-window expiry edge
    cyc(0, 1, 1, 3'd0, "R3");
    idle_cycles(NMIC - 1, "R9");
    cyc(0, 1, 1, 3'd7, "R9");
    idle_cycles(NMIC - 1, "R9");
    cyc(0, 0, 0, '0, "R9");
    // R9: stop on the second-window expiry edge
    idle_cycles(RSTC - 1, "R9");
    cyc(0, 1, 0, 3'd0, "R9");
    idle_cycles(RSTC + 2, "R9");

    // random mix, with occasional mid-run reset
    for (int i = 0; i < 4000; i++) begin
      bit w, e, r;
      logic [KW-1:0] k;
      r = ($urandom % 500) == 0;
      w = ($urandom % 9) == 0;
      e = $urandom % 2;
      k = ($urandom % 2) ? ~m_key : KW'($urandom);
      cyc(r, w, e, k, "R7");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule